// File: doc/BRIEF.md
# Memory Operand Address Decoder

This block sits behind an instruction-byte stream at the point where the opcode has been consumed and the next byte is the register/addressing byte. It takes bytes one per cycle on a valid strobe. It reads the addressing byte first, then a scale/index/base byte when the encoding calls for one, and then a little-endian displacement of 0, 1, 2 or 4 bytes. It takes exactly the number of bytes the encoding needs and no more. The address width (16, 32 or 64 bits) and the three register-extension bits are sampled together with the first byte.

When the last byte is taken, the block raises a one-cycle completion pulse. With it come the extended register-field operand and either a direct register operand or a memory description. The memory description gives the base register, the index register, the scale factor, the displacement width and the sign-extended displacement. The 16-bit base-pair forms are reported through the same base and index outputs, using register numbers BX=3, BP=5, SI=6 and DI=7. A new first byte may follow in the cycle right after the last byte of the previous operand, with no idle cycle between them.

Top module: `ea_decode_top`

## Requirements
- R1: The first byte is split into mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0. `reg_op` reports {rex_r, reg}.
- R2: When mod = 3, `rm_is_reg` is 1 and `rm_reg` = {rex_b, rm}. No base and no index are valid, `disp_bytes` = 0, `disp` = 0 and `consumed` = 1.
- R3: With `addr_mode` = 0 (16-bit) and mod other than 3, rm selects base/index as follows: 0→BX+SI, 1→BX+DI, 2→BP+SI, 3→BP+DI, 4→SI, 5→DI, 6→BP, 7→BX, with scale 1. Mod 1 adds a 1-byte displacement, mod 2 adds a 2-byte displacement, and mod 0 adds none. No scale/index/base byte is ever read in this mode.
- R4: With 16-bit addressing, mod 0 with rm 6 gives no base and no index, with a 2-byte displacement.
- R5: With `addr_mode` 1 (32-bit) or 2 (64-bit) and mod other than 3, rm low bits = 4 makes the second byte a scale/index/base byte. Any other rm gives base {rex_b, rm} with no index and scale 1. Mod 1 takes a 1-byte displacement and mod 2 takes a 4-byte displacement.
- R6: With 32/64-bit addressing, mod 0 with rm low bits = 5 gives no base and a 4-byte displacement.
- R7: In the scale/index/base byte, bits 7:6 give the scale (0,1,2,3 → `scale` 1,2,4,8), bits 5:3 the index and bits 2:0 the base. The index is {rex_x, index}, except that an extended value of 4 means no index. The base is {rex_b, base}.
- R8: A base field of 5 with mod 0 gives no base and a 4-byte displacement. With mod 1 or 2 it gives base {rex_b, 5} and a 1- or 4-byte displacement.
- R9: Displacement bytes arrive least significant first. `disp` is the value sign-extended to DISP_W bits, and `disp_bytes` gives its width.
- R10: `done` pulses for one cycle, in the cycle after the final byte is accepted. `consumed` = 1 + (1 if a scale/index/base byte was read) + `disp_bytes`, in the range 1 to 6. Cycles with `byte_vld` low are waited out.
- R11: `addr_mode` = 3 is reserved. The block then raises `done` with `fault` = 1 and `consumed` = 1 after the first byte, and reads no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A byte is offered on byte_in this cycle |
| byte_in | input | 8 | Instruction byte |
| addr_mode | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit, 3: reserved; sampled with first byte |
| rex_r | input | 1 | Extension bit for the reg field |
| rex_x | input | 1 | Extension bit for the index field |
| rex_b | input | 1 | Extension bit for rm / base field |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Reserved address mode seen |
| consumed | output | 3 | Bytes taken for this operand |
| reg_op | output | 4 | Extended reg field |
| rm_is_reg | output | 1 | Operand is a register, not memory |
| rm_reg | output | 4 | Register operand when rm_is_reg |
| base_vld | output | 1 | A base register is used |
| base_reg | output | 4 | Base register number |
| index_vld | output | 1 | An index register is used |
| index_reg | output | 4 | Index register number |
| scale | output | 4 | Index scale factor 1, 2, 4 or 8 |
| disp_bytes | output | 3 | Displacement width in bytes |
| disp | output | DISP_W | Sign-extended displacement |

## Verification
Every result of an operand appears exactly one cycle after the clock edge that accepts its final byte, and all of the results appear in that same cycle. Nothing is due after the intermediate bytes. The bench drives each byte just after a rising edge and records the cycle count at which that operand's results are due. It compares at every falling edge: when a due entry matches the current cycle it checks all fields, and in every other cycle it checks that `done` is low. Gaps in `byte_vld` and back-to-back operands shift the due cycle only through the bytes actually driven.

// File: rtl/ea_decode_pkg.sv
`timescale 1ns/1ps
package ea_decode_pkg;

  typedef enum logic [1:0] {
    AM_16   = 2'd0,
    AM_32   = 2'd1,
    AM_64   = 2'd2,
    AM_RSVD = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2
  } dec_state_e;

  localparam int REG_W  = 4;
  localparam int RAW_W  = 32;

  localparam logic [3:0] R_BX = 4'd3;
  localparam logic [3:0] R_BP = 4'd5;
  localparam logic [3:0] R_SI = 4'd6;
  localparam logic [3:0] R_DI = 4'd7;

  typedef struct packed {
    logic             base_vld;
    logic [REG_W-1:0] base;
    logic             idx_vld;
    logic [REG_W-1:0] idx;
    logic [3:0]       scale;
    logic [2:0]       dlen;
  } ea_t;

  // Displacement width from mod; wide selects 4 bytes over 2 for mod 2.
  function automatic logic [2:0] disp_len_for_mod(input logic [1:0] mod, input logic wide);
    case (mod)
      2'd1:    disp_len_for_mod = 3'd1;
      2'd2:    disp_len_for_mod = wide ? 3'd4 : 3'd2;
      default: disp_len_for_mod = 3'd0;
    endcase
  endfunction

  function automatic logic [3:0] scale_factor(input logic [1:0] ss);
    scale_factor = 4'd1 << ss;
  endfunction

  // Drop a byte into a little-endian raw accumulator at byte lane pos.
  function automatic logic [RAW_W-1:0] place_byte(input logic [RAW_W-1:0] acc,
                                                  input logic [7:0] b,
                                                  input logic [1:0] pos);
    place_byte = acc | ({24'd0, b} << {pos, 3'b000});
  endfunction

  function automatic logic [63:0] sext_disp(input logic [RAW_W-1:0] raw, input logic [2:0] n);
    case (n)
      3'd1:    sext_disp = {{56{raw[7]}},  raw[7:0]};
      3'd2:    sext_disp = {{48{raw[15]}}, raw[15:0]};
      3'd4:    sext_disp = {{32{raw[31]}}, raw[31:0]};
      default: sext_disp = 64'd0;
    endcase
  endfunction

  function automatic ea_t ea_none();
    ea_t e;
    e.base_vld = 1'b0;
    e.base     = '0;
    e.idx_vld  = 1'b0;
    e.idx      = '0;
    e.scale    = 4'd1;
    e.dlen     = 3'd0;
    return e;
  endfunction

  // 16-bit base-pair table, expressed as base/index register numbers.
  function automatic ea_t ea16(input logic [1:0] mod, input logic [2:0] rm);
    ea_t e;
    e = ea_none();
    e.dlen = disp_len_for_mod(mod, 1'b0);
    case (rm)
      3'd0: begin e.base = R_BX; e.idx = R_SI; e.idx_vld = 1'b1; end
      3'd1: begin e.base = R_BX; e.idx = R_DI; e.idx_vld = 1'b1; end
      3'd2: begin e.base = R_BP; e.idx = R_SI; e.idx_vld = 1'b1; end
      3'd3: begin e.base = R_BP; e.idx = R_DI; e.idx_vld = 1'b1; end
      3'd4: e.base = R_SI;
      3'd5: e.base = R_DI;
      3'd6: e.base = R_BP;
      default: e.base = R_BX;
    endcase
    e.base_vld = 1'b1;
    if (mod == 2'd0 && rm == 3'd6) begin
      e.base_vld = 1'b0;
      e.base     = '0;
      e.dlen     = 3'd2;
    end
    return e;
  endfunction

endpackage

// File: rtl/ea_modrm_classify.sv
`timescale 1ns/1ps
module ea_modrm_classify
  import ea_decode_pkg::*;
(
  input  logic [7:0]  modrm,
  input  addr_mode_e  am,
  input  logic        ext_b,
  output logic        is_reg,
  output logic        need_sib,
  output logic        bad_mode,
  output ea_t         ea
);

  logic [1:0] mod_f;
  logic [2:0] rm_f;

  assign mod_f = modrm[7:6];
  assign rm_f  = modrm[2:0];

  always_comb begin
    bad_mode = (am == AM_RSVD);
    is_reg   = !bad_mode && (mod_f == 2'd3);
    need_sib = 1'b0;
    ea       = ea_none();
    if (!bad_mode && !is_reg) begin
      if (am == AM_16) begin
        ea = ea16(mod_f, rm_f);
      end else if (rm_f == 3'd4) begin
        need_sib = 1'b1;
      end else if (mod_f == 2'd0 && rm_f == 3'd5) begin
        ea.dlen = 3'd4;
      end else begin
        ea.base_vld = 1'b1;
        ea.base     = {ext_b, rm_f};
        ea.dlen     = disp_len_for_mod(mod_f, 1'b1);
      end
    end
  end

endmodule

// File: rtl/ea_sib_classify.sv
`timescale 1ns/1ps
module ea_sib_classify
  import ea_decode_pkg::*;
(
  input  logic [7:0] sib,
  input  logic [1:0] mod_f,
  input  logic       ext_x,
  input  logic       ext_b,
  output ea_t        ea
);

  logic [3:0] idx_ext;
  logic [2:0] base_f;

  assign idx_ext = {ext_x, sib[5:3]};
  assign base_f  = sib[2:0];

  always_comb begin
    ea         = ea_none();
    ea.scale   = scale_factor(sib[7:6]);
    ea.idx_vld = (idx_ext != 4'd4);
    ea.idx     = ea.idx_vld ? idx_ext : 4'd0;
    if (base_f == 3'd5 && mod_f == 2'd0) begin
      ea.dlen = 3'd4;
    end else begin
      ea.base_vld = 1'b1;
      ea.base     = {ext_b, base_f};
      ea.dlen     = disp_len_for_mod(mod_f, 1'b1);
    end
  end

endmodule

// File: rtl/ea_disp_collect.sv
`timescale 1ns/1ps
module ea_disp_collect
  import ea_decode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [1:0]       pos,
  input  logic [7:0]       byte_in,
  output logic [RAW_W-1:0] merged
);

  logic [RAW_W-1:0] acc_q;

  assign merged = place_byte(acc_q, byte_in, pos);

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (ld)  acc_q <= merged;
  end

  AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ld && !clr |=> ((acc_q >> {$past(pos), 3'b000}) & 32'hFF) == {24'd0, $past(byte_in)}); // R9

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> merged == place_byte('0, byte_in, pos)); // R9

endmodule

// File: rtl/ea_decode_top.sv
`timescale 1ns/1ps
module ea_decode_top
  import ea_decode_pkg::*;
#(
  parameter int DISP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic [1:0]        addr_mode,
  input  logic              rex_r,
  input  logic              rex_x,
  input  logic              rex_b,
  output logic              done,
  output logic              fault,
  output logic [2:0]        consumed,
  output logic [3:0]        reg_op,
  output logic              rm_is_reg,
  output logic [3:0]        rm_reg,
  output logic              base_vld,
  output logic [3:0]        base_reg,
  output logic              index_vld,
  output logic [3:0]        index_reg,
  output logic [3:0]        scale,
  output logic [2:0]        disp_bytes,
  output logic [DISP_W-1:0] disp
);

  localparam int MAX_LEN = 6;

  dec_state_e       state_q;
  addr_mode_e       am_in;
  addr_mode_e       am_q;
  logic [1:0]       mod_q;
  logic             xq, bq;
  logic [2:0]       need_q;
  logic [1:0]       pos_q;
  logic [2:0]       cnt_q;
  logic             sib_seen_q;

  logic             done_q, fault_q, rm_is_reg_q;
  logic [2:0]       consumed_q;
  logic [3:0]       reg_op_q, rm_reg_q;
  ea_t              ea_q;
  logic [63:0]      disp_q;

  // Named internal events for the checks.
  logic             take_first, take_sib, take_disp, last_disp;
  logic             mc_is_reg, mc_need_sib, mc_bad;
  ea_t              mc_ea, sc_ea;
  logic [RAW_W-1:0] disp_merged;
  logic             sib_seen;

  assign am_in      = addr_mode_e'(addr_mode);
  assign take_first = byte_vld && (state_q == ST_FIRST);
  assign take_sib   = byte_vld && (state_q == ST_SIB);
  assign take_disp  = byte_vld && (state_q == ST_DISP);
  assign last_disp  = take_disp && ({1'b0, pos_q} == need_q - 3'd1);
  assign sib_seen   = sib_seen_q;

  ea_modrm_classify u_modrm (
    .modrm    (byte_in),
    .am       (am_in),
    .ext_b    (rex_b),
    .is_reg   (mc_is_reg),
    .need_sib (mc_need_sib),
    .bad_mode (mc_bad),
    .ea       (mc_ea)
  );

  ea_sib_classify u_sib (
    .sib   (byte_in),
    .mod_f (mod_q),
    .ext_x (xq),
    .ext_b (bq),
    .ea    (sc_ea)
  );

  ea_disp_collect u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (take_first),
    .ld      (take_disp),
    .pos     (pos_q),
    .byte_in (byte_in),
    .merged  (disp_merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_FIRST;
      am_q        <= AM_32;
      mod_q       <= '0;
      xq          <= 1'b0;
      bq          <= 1'b0;
      need_q      <= '0;
      pos_q       <= '0;
      cnt_q       <= '0;
      sib_seen_q  <= 1'b0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      rm_is_reg_q <= 1'b0;
      consumed_q  <= '0;
      reg_op_q    <= '0;
      rm_reg_q    <= '0;
      ea_q        <= ea_none();
      disp_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_FIRST: if (take_first) begin
          am_q        <= am_in;
          mod_q       <= byte_in[7:6];
          xq          <= rex_x;
          bq          <= rex_b;
          reg_op_q    <= {rex_r, byte_in[5:3]};
          rm_is_reg_q <= mc_is_reg;
          rm_reg_q    <= mc_is_reg ? {rex_b, byte_in[2:0]} : 4'd0;
          fault_q     <= mc_bad;
          ea_q        <= mc_ea;
          sib_seen_q  <= 1'b0;
          cnt_q       <= 3'd1;
          pos_q       <= 2'd0;
          disp_q      <= '0;
          if (mc_bad || mc_is_reg || (!mc_need_sib && mc_ea.dlen == 3'd0)) begin
            done_q     <= 1'b1;
            consumed_q <= 3'd1;
          end else if (mc_need_sib) begin
            state_q <= ST_SIB;
          end else begin
            need_q  <= mc_ea.dlen;
            state_q <= ST_DISP;
          end
        end
        ST_SIB: if (take_sib) begin
          ea_q       <= sc_ea;
          sib_seen_q <= 1'b1;
          cnt_q      <= 3'd2;
          if (sc_ea.dlen == 3'd0) begin
            done_q     <= 1'b1;
            consumed_q <= 3'd2;
            state_q    <= ST_FIRST;
          end else begin
            need_q  <= sc_ea.dlen;
            state_q <= ST_DISP;
          end
        end
        ST_DISP: if (take_disp) begin
          pos_q <= pos_q + 2'd1;
          cnt_q <= cnt_q + 3'd1;
          if (last_disp) begin
            done_q     <= 1'b1;
            consumed_q <= cnt_q + 3'd1;
            disp_q     <= sext_disp(disp_merged, need_q);
            state_q    <= ST_FIRST;
          end
        end
        default: state_q <= ST_FIRST;
      endcase
    end
  end

  assign done       = done_q;
  assign fault      = fault_q;
  assign consumed   = consumed_q;
  assign reg_op     = reg_op_q;
  assign rm_is_reg  = rm_is_reg_q;
  assign rm_reg     = rm_reg_q;
  assign base_vld   = ea_q.base_vld;
  assign base_reg   = ea_q.base;
  assign index_vld  = ea_q.idx_vld;
  assign index_reg  = ea_q.idx;
  assign scale      = ea_q.scale;
  assign disp_bytes = ea_q.dlen;
  assign disp       = disp_q[DISP_W-1:0];

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (consumed >= 3'd1) && (consumed <= 3'(MAX_LEN))); // R10

  AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !rm_is_reg |-> consumed == 3'd1 + {2'd0, sib_seen} + disp_bytes); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(byte_vld)); // R10

  AST_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    done && rm_is_reg |-> consumed == 3'd1 && !base_vld && !index_vld && disp_bytes == 3'd0); // R2

  AST_SCALE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(scale) == 1); // R7

  AST_NO_SIB16: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SIB |-> am_q != AM_16 && am_q != AM_RSVD); // R11

  AST_FAULT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> consumed == 3'd1); // R11

  AST_NOBASE16: assert property (@(posedge clk) disable iff (!rst_n)
    done && am_q == AM_16 && !fault && !rm_is_reg && !base_vld |-> disp_bytes == 3'd2 && !index_vld); // R4

  AST_DISP8_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    done && disp_bytes == 3'd1 |-> (&disp[DISP_W-1:7]) || !(|disp[DISP_W-1:7])); // R9

endmodule

// File: tb/test_ea_decode_top.sv
`timescale 1ns/1ps
module test_ea_decode_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'd0;
  logic [1:0]  addr_mode = 2'd1;
  logic        rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0;
  logic        done, fault, rm_is_reg, base_vld, index_vld;
  logic [2:0]  consumed, disp_bytes;
  logic [3:0]  reg_op, rm_reg, base_reg, index_reg, scale;
  logic [63:0] disp;

  always #2 clk = ~clk;

  ea_decode_top #(.DISP_W(64)) i_ea_decode_top (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .addr_mode(addr_mode), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
    .done(done), .fault(fault), .consumed(consumed), .reg_op(reg_op),
    .rm_is_reg(rm_is_reg), .rm_reg(rm_reg), .base_vld(base_vld),
    .base_reg(base_reg), .index_vld(index_vld), .index_reg(index_reg),
    .scale(scale), .disp_bytes(disp_bytes), .disp(disp)
  );

  typedef struct {
    int     due;
    int     len;
    bit     flt;
    bit     isreg;
    int     rmreg;
    int     regop;
    bit     bv;
    int     base;
    bit     iv;
    int     idx;
    int     scl;
    int     dlen;
    longint dsp;
    string  tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input longint act, input longint exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exv);
    end
  endtask

  // Behavioural reference: walk the byte list the way the requirements read.
  function automatic exp_t model(input int mode, input bit r, input bit x, input bit b,
                                 input logic [7:0] bs [6], input string tag);
    exp_t e;
    int mod, rg, rm, k, sb, ii;
    longint v;
    mod = bs[0][7:6]; rg = bs[0][5:3]; rm = bs[0][2:0];
    e.tag = tag; e.due = 0; e.len = 1; e.flt = 0; e.isreg = 0; e.rmreg = 0;
    e.regop = (r ? 8 : 0) + rg; e.bv = 0; e.base = 0; e.iv = 0; e.idx = 0;
    e.scl = 1; e.dlen = 0; e.dsp = 0;
    if (mode == 3) begin e.flt = 1; return e; end
    if (mod == 3) begin e.isreg = 1; e.rmreg = (b ? 8 : 0) + rm; return e; end
    if (mode == 0) begin
      e.bv = 1;
      case (rm)
        0: begin e.base = 3; e.iv = 1; e.idx = 6; end
        1: begin e.base = 3; e.iv = 1; e.idx = 7; end
        2: begin e.base = 5; e.iv = 1; e.idx = 6; end
        3: begin e.base = 5; e.iv = 1; e.idx = 7; end
        4: e.base = 6;
        5: e.base = 7;
        6: e.base = 5;
        default: e.base = 3;
      endcase
      if (mod == 1) e.dlen = 1; else if (mod == 2) e.dlen = 2;
      if (mod == 0 && rm == 6) begin e.bv = 0; e.base = 0; e.dlen = 2; end
    end else if (rm == 4) begin
      e.len = 2;
      e.scl = 1 << bs[1][7:6];
      ii = (x ? 8 : 0) + bs[1][5:3];
      if (ii != 4) begin e.iv = 1; e.idx = ii; end
      sb = bs[1][2:0];
      if (sb == 5 && mod == 0) e.dlen = 4;
      else begin
        e.bv = 1; e.base = (b ? 8 : 0) + sb;
        e.dlen = (mod == 1) ? 1 : (mod == 2) ? 4 : 0;
      end
    end else if (rm == 5 && mod == 0) begin
      e.dlen = 4;
    end else begin
      e.bv = 1; e.base = (b ? 8 : 0) + rm;
      e.dlen = (mod == 1) ? 1 : (mod == 2) ? 4 : 0;
    end
    v = 0;
    for (int j = 0; j < e.dlen; j++) v = v + (longint'(bs[e.len + j]) << (8 * j));
    if (e.dlen > 0 && v[8 * e.dlen - 1]) v = v - (longint'(1) << (8 * e.dlen));
    e.dsp = v;
    e.len = e.len + e.dlen;
    k = 0;
    return e;
  endfunction

  task automatic run(input int mode, input bit r, input bit x, input bit b,
                     input logic [7:0] bs [6], input int gap, input string tag);
    exp_t e;
    e = model(mode, r, x, b, bs, tag);
    for (int k = 0; k < e.len; k++) begin
      @(posedge clk); #1;
      byte_vld = 1'b1; byte_in = bs[k];
      if (k == 0) begin addr_mode = 2'(mode); rex_r = r; rex_x = x; rex_b = b; end
      else begin addr_mode = 2'd3; rex_r = ~r; rex_x = ~x; rex_b = ~b; end
      if (k == e.len - 1) begin e.due = cyc + 1; q.push_back(e); end
      for (int g = 0; g < gap && k != e.len - 1; g++) begin
        @(posedge clk); #1; byte_vld = 1'b0; byte_in = 8'hA5;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(done == 1'b1, {e.tag, " R10 done"}, longint'(done), 1);
        chk(int'(consumed) == e.len, {e.tag, " R10 consumed"}, longint'(consumed), e.len);
        chk(fault == e.flt, {e.tag, " R11 fault"}, longint'(fault), e.flt);
        if (!e.flt) begin
          chk(int'(reg_op) == e.regop, {e.tag, " R1 reg_op"}, longint'(reg_op), e.regop);
          chk(rm_is_reg == e.isreg, {e.tag, " R2 rm_is_reg"}, longint'(rm_is_reg), e.isreg);
          if (e.isreg) chk(int'(rm_reg) == e.rmreg, {e.tag, " R2 rm_reg"}, longint'(rm_reg), e.rmreg);
          chk(base_vld == e.bv, {e.tag, " base_vld"}, longint'(base_vld), e.bv);
          if (e.bv) chk(int'(base_reg) == e.base, {e.tag, " base_reg"}, longint'(base_reg), e.base);
          chk(index_vld == e.iv, {e.tag, " index_vld"}, longint'(index_vld), e.iv);
          if (e.iv) chk(int'(index_reg) == e.idx, {e.tag, " index_reg"}, longint'(index_reg), e.idx);
          if (!e.isreg) chk(int'(scale) == e.scl, {e.tag, " R7 scale"}, longint'(scale), e.scl);
          chk(int'(disp_bytes) == e.dlen, {e.tag, " disp_bytes"}, longint'(disp_bytes), e.dlen);
          chk(disp == e.dsp, {e.tag, " R9 disp"}, disp, e.dsp);
        end
      end else begin
        chk(done == 1'b0, "R10 no spurious done", longint'(done), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b0, "R10 reset done", longint'(done), 0);
    rst_n = 1'b1;
    // R2 R1: register form, all extension bits set
    run(1, 1, 1, 1, '{8'hC8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R2");
    // R3: 16-bit BX+SI, no displacement
    run(0, 0, 0, 1, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R3");
    // R3 R9: 16-bit BP with negative 8-bit displacement
    run(0, 0, 0, 0, '{8'h46, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00}, 1, "R3");
    // R4: 16-bit direct 16-bit displacement
    run(0, 0, 0, 0, '{8'h06, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00}, 0, "R4");
    // R3: BP+DI with 16-bit displacement, negative
    run(0, 1, 0, 0, '{8'h9B, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'h00}, 2, "R3");
    // R3 R11: rm 4 in 16-bit is SI, no extra byte
    run(0, 0, 0, 0, '{8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R3");
    // R6: 32-bit no base, 4-byte displacement
    run(1, 0, 0, 0, '{8'h05, 8'h78, 8'h56, 8'h34, 8'h12, 8'h00}, 0, "R6");
    // R5: extended base, 8-bit displacement
    run(2, 0, 0, 1, '{8'h41, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00}, 1, "R5");
    // R5: mod 2, 4-byte negative displacement
    run(1, 0, 0, 0, '{8'h83, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00}, 0, "R5");
    // R7: scale 4 with extended index
    run(2, 0, 1, 0, '{8'h04, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R7");
    // R7: index 4 without extension means none
    run(1, 0, 0, 0, '{8'h44, 8'h24, 8'h10, 8'h00, 8'h00, 8'h00}, 0, "R7");
    // R7: index 4 with extension is register 12, scale 8
    run(2, 0, 1, 0, '{8'h04, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00}, 3, "R7");
    // R8: base 5 with mod 0, six bytes total
    run(2, 0, 0, 0, '{8'h04, 8'h05, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 0, "R8");
    // R8: base 5 with mod 2 and REX.B
    run(2, 0, 0, 1, '{8'h84, 8'h15, 8'h01, 8'h02, 8'h03, 8'h04}, 1, "R8");
    // R8: base 5 with mod 1
    run(1, 0, 0, 0, '{8'h44, 8'h25, 8'hF0, 8'h00, 8'h00, 8'h00}, 0, "R8");
    // R5: rm 12 via REX.B still needs the extra byte
    run(2, 0, 0, 1, '{8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R5");
    // R11: reserved mode faults after one byte
    run(3, 0, 0, 0, '{8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R11");
    // R10: operand right after a fault decodes normally
    run(1, 0, 0, 0, '{8'h42, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00}, 0, "R10");
    @(posedge clk); #1; byte_vld = 1'b0;
    repeat (4) @(posedge clk);
    chk(q.size() == 0, "R10 all results seen", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule